// File: doc/BRIEF.md
# Pixel Pedestal and Zero-Suppression Processor

This block cleans the digitized samples of one pixel matrix before they go off chip. Each row group of `LANES` rows is read out in parallel, so one input beat carries one sample per lane for a single column. A frame is `NCOL` beats, one for each column in ascending order. Each sample has its stored per-pixel pedestal removed first. The block then works out a common-mode offset for the whole row group. It subtracts that offset from every pixel and sends on only the pixels whose corrected value is above a programmable threshold. Each kept pixel leaves as one word holding its row, column and value on a valid/ready stream.

The common-mode offset needs the whole frame, so the block has three phases. It first collects a frame into a local buffer. It then divides the accumulated sum by the number of samples that take part. Last, it walks the buffer and emits the hits. Input is refused while a frame is being divided or emitted. Output back-pressure holds the walk in place, so no hit is lost and nothing needs to be dropped. A raw mode skips all correction and forwards every sample unchanged, which is how pedestal values are acquired. Pedestals are loaded through a single-word write port that addresses the pixel by row and column.

Top module: `pix_zs_proc`

## Requirements
- R1: After reset `m_valid` is 0 and `s_ready` is 1.
- R2: A write with `ped_we` high stores `ped_data` as the pedestal of pixel (`ped_row`, `ped_col`). Outside raw mode, the pedestal-subtracted value of a sample is d = sample − pedestal, a signed value in −255..255.
- R3: A frame is `NCOL` accepted beats. Beat k is column k, and lane i of `s_samples` (bits 8i+7..8i) is row `s_grp`·`LANES`+i, with the group taken from the first beat. After the last beat `s_ready` stays low until every word of that frame has been sent, and `s_ready` is never high while `m_valid` is high.
- R4: The common-mode offset of a frame is the sum of all d with d ≤ `thresh`, divided by their count and truncated toward zero. It is 0 when no sample qualifies.
- R5: The corrected value is d minus the common-mode offset, saturated to the range −256..255.
- R6: Outside raw mode, a pixel is emitted only when its corrected value is strictly greater than `thresh`. `thresh` is held constant during a frame.
- R7: Output word layout: `m_data[25:16]` is the row, `m_data[15:8]` the column and `m_data[7:0]` the value. Words leave in ascending column order, and within a column in ascending lane order.
- R8: When `raw_mode` is high on the first beat of a frame, every one of the `LANES`·`NCOL` samples is emitted with its unmodified 8-bit sample as the value, and no pedestal or offset is applied.
- R9: While `m_valid` is high and `m_ready` low, `m_valid` stays high and `m_data` holds. Every hit is delivered, whatever the pattern on `m_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_mode | input | 1 | Forward uncorrected samples; sampled on the first beat of a frame |
| thresh | input | 8 | Hit threshold, unsigned |
| ped_we | input | 1 | Pedestal write strobe |
| ped_row | input | ROWW | Row of the pixel whose pedestal is written |
| ped_col | input | COLW | Column of the pixel whose pedestal is written |
| ped_data | input | 8 | Pedestal value |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when both are high |
| s_grp | input | GW | Row group of the frame |
| s_samples | input | 8·LANES | One 8-bit unsigned sample per lane |
| m_valid | output | 1 | Output hit valid |
| m_ready | input | 1 | Downstream accepts the hit |
| m_data | output | 26 | Row, column and value of the hit |

## Verification
Flat frames with a positive offset and a few large hits show whether the pedestal and offset are subtracted and whether hits are kept out of the average. A negative offset with a fractional mean tells truncation toward zero apart from flooring. Frames where every pixel is a hit, or where one pixel sits exactly on the threshold and one just above it, isolate the zero-count case and the strict comparison. A frame with a pedestal of zero and a strongly negative offset drives the corrected value into saturation. Raw frames and frames under random back-pressure separate the bypass and the ordering of words from the correction path, and check that stalls lose nothing.

// File: rtl/pzs_pkg.sv
package pzs_pkg;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_DIVIDE  = 2'd1,
    ST_EMIT    = 2'd2
  } pzs_state_e;

  // Clamp a wide signed difference into the 9-bit corrected range.
  function automatic logic signed [8:0] sat9(input logic signed [10:0] v);
    if (v > 11'sd255)       return 9'sd255;
    else if (v < -11'sd256) return -9'sd256;
    else                    return v[8:0];
  endfunction

endpackage

// File: rtl/pzs_ped_ram.sv
module pzs_ped_ram #(
  parameter int LANES = 4,
  parameter int NGRP  = 4,
  parameter int NCOL  = 16,
  localparam int LW   = $clog2(LANES),
  localparam int GW   = $clog2(NGRP),
  localparam int COLW = $clog2(NCOL),
  localparam int ROWW = GW + LW
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [ROWW-1:0]       wrow,
  input  logic [COLW-1:0]       wcol,
  input  logic [7:0]            wdata,
  input  logic [GW-1:0]         rgrp,
  input  logic [COLW-1:0]       rcol,
  output logic [LANES*8-1:0]    rdata
);
  localparam int DEPTH = NGRP * NCOL;

  // One bank per lane so that a whole beat reads in one cycle.
  for (genvar l = 0; l < LANES; l++) begin : g_bank
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && (wrow[LW-1:0] == LW'(l)))
        mem[{wrow[ROWW-1:LW], wcol}] <= wdata;
    end

    assign rdata[l*8 +: 8] = mem[{rgrp, rcol}];
  end

endmodule

// File: rtl/pzs_div.sv
module pzs_div #(
  parameter int NW = 15,
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quotient
);
  localparam int CNTW = $clog2(NW + 1);

  logic [DW:0]     rem_q;
  logic [NW-1:0]   quo_q;
  logic [DW-1:0]   dv_q;
  logic [NW-1:0]   dd_q;
  logic [CNTW-1:0] cnt_q;
  logic            busy_q;

  logic [DW:0] shifted, rem_n;
  logic        fits;

  always_comb begin
    shifted = {rem_q[DW-1:0], quo_q[NW-1]};
    fits    = shifted >= {1'b0, dv_q};
    rem_n   = fits ? shifted - {1'b0, dv_q} : shifted;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dv_q   <= '0;
      dd_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q  <= '0;
        quo_q  <= dividend;
        dd_q   <= dividend;
        dv_q   <= divisor;
        cnt_q  <= CNTW'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_n;
        quo_q <= {quo_q[NW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNTW'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;

  // R4: the quotient handed out is the truncated ratio of the latched operands.
  logic [NW+DW:0] prod_lo, prod_hi;
  assign prod_lo = (NW+DW+1)'(quo_q) * (NW+DW+1)'(dv_q);
  assign prod_hi = prod_lo + (NW+DW+1)'(dv_q);

  a_r4_quotient_exact: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prod_lo <= (NW+DW+1)'(dd_q)) && ((NW+DW+1)'(dd_q) < prod_hi));

endmodule

// File: rtl/pix_zs_proc.sv
module pix_zs_proc #(
  parameter int LANES = 4,
  parameter int NGRP  = 4,
  parameter int NCOL  = 16,
  localparam int LW   = $clog2(LANES),
  localparam int GW   = $clog2(NGRP),
  localparam int COLW = $clog2(NCOL),
  localparam int ROWW = GW + LW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 raw_mode,
  input  logic [7:0]           thresh,
  input  logic                 ped_we,
  input  logic [ROWW-1:0]      ped_row,
  input  logic [COLW-1:0]      ped_col,
  input  logic [7:0]           ped_data,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [GW-1:0]        s_grp,
  input  logic [LANES*8-1:0]   s_samples,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [25:0]          m_data
);
  import pzs_pkg::*;

  localparam int NPIX = LANES * NCOL;
  localparam int PW   = $clog2(NPIX);
  localparam int SW   = 9 + PW;
  localparam int CW   = PW + 1;

  pzs_state_e              state_q;
  logic [COLW-1:0]         col_q;
  logic [GW-1:0]           grp_q;
  logic                    raw_q;
  logic signed [SW-1:0]    sum_q;
  logic [CW-1:0]           cnt_q;
  logic                    neg_q;
  logic signed [8:0]       cm_q;
  logic [PW-1:0]           ptr_q;
  logic signed [8:0]       buf_q [NPIX];

  // ---------------- collection ----------------
  logic                    accept, first_beat, last_beat, eff_raw;
  logic [GW-1:0]           eff_grp;
  logic [LANES*8-1:0]      ped_rd;
  logic signed [8:0]       d_a [LANES];
  logic signed [SW-1:0]    beat_sum, sum_n;
  logic [CW-1:0]           beat_cnt, cnt_n;
  logic [SW-1:0]           sum_mag;

  assign s_ready    = (state_q == ST_COLLECT);
  assign accept     = s_valid && s_ready;
  assign first_beat = (col_q == '0);
  assign last_beat  = (col_q == COLW'(NCOL - 1));
  assign eff_raw    = first_beat ? raw_mode : raw_q;
  assign eff_grp    = first_beat ? s_grp : grp_q;

  pzs_ped_ram #(.LANES(LANES), .NGRP(NGRP), .NCOL(NCOL)) i_ped (
    .clk   (clk),
    .we    (ped_we),
    .wrow  (ped_row),
    .wcol  (ped_col),
    .wdata (ped_data),
    .rgrp  (eff_grp),
    .rcol  (col_q),
    .rdata (ped_rd)
  );

  always_comb begin
    beat_sum = '0;
    beat_cnt = '0;
    for (int l = 0; l < LANES; l++) begin
      if (eff_raw)
        d_a[l] = $signed({1'b0, s_samples[l*8 +: 8]});
      else
        d_a[l] = $signed({1'b0, s_samples[l*8 +: 8]}) - $signed({1'b0, ped_rd[l*8 +: 8]});
      if (d_a[l] <= $signed({1'b0, thresh})) begin
        beat_sum = beat_sum + SW'(d_a[l]);
        beat_cnt = beat_cnt + CW'(1);
      end
    end
    sum_n   = (first_beat ? '0 : sum_q) + beat_sum;
    cnt_n   = (first_beat ? '0 : cnt_q) + beat_cnt;
    sum_mag = sum_n[SW-1] ? SW'(-sum_n) : SW'(sum_n);
  end

  // ---------------- common-mode divide ----------------
  logic            div_start, div_done;
  logic [SW-1:0]   div_q;

  assign div_start = accept && last_beat && !eff_raw && (cnt_n != '0);

  pzs_div #(.NW(SW), .DW(CW)) i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (sum_mag),
    .divisor  (cnt_n),
    .done     (div_done),
    .quotient (div_q)
  );

  // ---------------- emission ----------------
  logic signed [8:0]  cur, corr;
  logic               keep, advance;

  always_comb begin
    cur     = buf_q[ptr_q];
    corr    = sat9(11'(cur) - 11'(cm_q));
    keep    = raw_q || (corr > $signed({1'b0, thresh}));
    m_valid = (state_q == ST_EMIT) && keep;
    advance = (state_q == ST_EMIT) && (!keep || m_ready);
    m_data  = {10'({grp_q, ptr_q[LW-1:0]}), 8'(ptr_q[PW-1:LW]),
               raw_q ? cur[7:0] : corr[7:0]};
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int l = 0; l < LANES; l++)
        buf_q[{col_q, LW'(l)}] <= d_a[l];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      col_q   <= '0;
      grp_q   <= '0;
      raw_q   <= 1'b0;
      sum_q   <= '0;
      cnt_q   <= '0;
      neg_q   <= 1'b0;
      cm_q    <= '0;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_COLLECT: if (accept) begin
          sum_q <= sum_n;
          cnt_q <= cnt_n;
          if (first_beat) begin
            grp_q <= s_grp;
            raw_q <= raw_mode;
          end
          if (last_beat) begin
            col_q <= '0;
            ptr_q <= '0;
            neg_q <= sum_n[SW-1];
            if (div_start) begin
              state_q <= ST_DIVIDE;
            end else begin
              cm_q    <= '0;
              state_q <= ST_EMIT;
            end
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        ST_DIVIDE: if (div_done) begin
          cm_q    <= neg_q ? -$signed(div_q[8:0]) : $signed(div_q[8:0]);
          state_q <= ST_EMIT;
        end
        ST_EMIT: if (advance) begin
          if (ptr_q == PW'(NPIX - 1)) state_q <= ST_COLLECT;
          else                        ptr_q   <= ptr_q + 1'b1;
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  // ---------------- assertions ----------------
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  a_r3_no_input_while_output: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready);

  a_r3_frame_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last_beat) |=> !s_ready);

  a_r6_above_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !raw_q) |-> (m_data[7:0] > thresh));

  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> (s_ready && !m_valid));

endmodule

// File: tb/test_pix_zs_proc.sv
module test_pix_zs_proc;
  localparam int LANES = 4;
  localparam int NGRP  = 4;
  localparam int NCOL  = 16;
  localparam int NROW  = LANES * NGRP;
  localparam int NPIX  = LANES * NCOL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raw_mode = 1'b0;
  logic [7:0]  thresh = 8'd0;
  logic        ped_we = 1'b0;
  logic [3:0]  ped_row = '0;
  logic [3:0]  ped_col = '0;
  logic [7:0]  ped_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [1:0]  s_grp = '0;
  logic [31:0] s_samples = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [25:0] m_data;

  always #4 clk = ~clk;

  pix_zs_proc #(.LANES(LANES), .NGRP(NGRP), .NCOL(NCOL)) i_pix_zs_proc (
    .clk, .rst_n, .raw_mode, .thresh, .ped_we, .ped_row, .ped_col, .ped_data,
    .s_valid, .s_ready, .s_grp, .s_samples, .m_valid, .m_ready, .m_data
  );

  int n_checks = 0;
  int n_errors = 0;

  int ped_m [NROW][NCOL];
  int smp   [LANES][NCOL];
  logic [25:0] exp_w [NPIX];
  int          exp_n;
  logic [25:0] got_w [NPIX];
  int          got_n;

  // Monitor, back-pressure driver and stall checker in one process.
  logic        bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        prev_stall = 1'b0;
  logic [25:0] prev_data = '0;
  int          stall_err = 0;
  int          overlap_err = 0;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = bp_en ? lfsr[0] : 1'b1;
    if (prev_stall && (!m_valid || m_data != prev_data)) stall_err++;
    if (m_valid && s_ready) overlap_err++;
    if (m_valid && m_ready) begin
      if (got_n < NPIX) got_w[got_n] = m_data;
      got_n++;
    end
    prev_stall = m_valid && !m_ready;
    prev_data  = m_data;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic write_ped(input int r, input int c, input int v);
    @(negedge clk);
    ped_we = 1'b1; ped_row = 4'(r); ped_col = 4'(c); ped_data = 8'(v);
    @(negedge clk);
    ped_we = 1'b0;
    ped_m[r][c] = v;
  endtask

  task automatic load_ped_table();
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++)
        write_ped(r, c, (r * 37 + c * 11) % 60 + 20);
  endtask

  // Reference model built from R2..R8.
  task automatic build_expect(input int grp, input bit raw, input int thr);
    int d [LANES][NCOL];
    int sum, cnt, cm, v;
    sum = 0; cnt = 0; exp_n = 0;
    for (int c = 0; c < NCOL; c++)
      for (int l = 0; l < LANES; l++) begin
        d[l][c] = raw ? smp[l][c] : smp[l][c] - ped_m[grp*LANES+l][c];
        if (d[l][c] <= thr) begin sum += d[l][c]; cnt++; end
      end
    cm = (raw || cnt == 0) ? 0 : sum / cnt;
    for (int c = 0; c < NCOL; c++)
      for (int l = 0; l < LANES; l++) begin
        v = d[l][c] - cm;
        if (v > 255) v = 255;
        if (v < -256) v = -256;
        if (raw || v > thr) begin
          exp_w[exp_n] = {10'(grp*LANES+l), 8'(c), 8'(raw ? smp[l][c] : v)};
          exp_n++;
        end
      end
  endtask

  task automatic run_frame(input int grp, input bit raw, input int thr);
    @(negedge clk);
    got_n = 0; stall_err = 0; overlap_err = 0;
    thresh = 8'(thr);
    for (int c = 0; c < NCOL; c++) begin
      s_valid = 1'b1;
      s_grp = 2'(grp);
      raw_mode = (c == 0) ? raw : ~raw;  // only the first beat counts (R8)
      for (int l = 0; l < LANES; l++) s_samples[l*8 +: 8] = 8'(smp[l][c]);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0;
    raw_mode = 1'b0;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(got_n == exp_n, req, "hit count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      check(got_w[i] == exp_w[i], req, $sformatf("word %0d", i), got_w[i], exp_w[i]);
    check(overlap_err == 0, "R3", "s_ready high with m_valid", overlap_err, 0);
  endtask

  task automatic t_reset();
    check(s_ready == 1'b1, "R1", "s_ready after reset", s_ready, 1);
    check(m_valid == 1'b0, "R1", "m_valid after reset", m_valid, 0);
  endtask

  task automatic t_raw();
    for (int c = 0; c < NCOL; c++)
      for (int l = 0; l < LANES; l++) smp[l][c] = (l * 3 + c * 7 + 250) % 256;
    build_expect(3, 1'b1, 200);
    run_frame(3, 1'b1, 200);
    compare("R8 R7 raw bypass");
  endtask

  task automatic t_common_pos();
    for (int c = 0; c < NCOL; c++)
      for (int l = 0; l < LANES; l++) smp[l][c] = ped_m[2*LANES+l][c] + 6;
    smp[1][3] += 100; smp[3][9] += 120; smp[0][15] += 40;
    build_expect(2, 1'b0, 20);
    run_frame(2, 1'b0, 20);
    compare("R2 R4 R6 positive offset");
  endtask

  task automatic t_common_neg();
    for (int c = 0; c < NCOL; c++)
      for (int l = 0; l < LANES; l++)
        smp[l][c] = ped_m[l][c] - 3 - ((c + l) % 3 == 0 ? 1 : 0);
    smp[2][7] += 80;
    build_expect(0, 1'b0, 25);
    run_frame(0, 1'b0, 25);
    compare("R4 truncation toward zero");
  endtask

  task automatic t_all_hits();
    for (int c = 0; c < NCOL; c++)
      for (int l = 0; l < LANES; l++) smp[l][c] = ped_m[LANES+l][c] + 50;
    build_expect(1, 1'b0, 10);
    run_frame(1, 1'b0, 10);
    compare("R4 empty average");
  endtask

  task automatic t_boundary();
    for (int c = 0; c < NCOL; c++)
      for (int l = 0; l < LANES; l++) smp[l][c] = ped_m[3*LANES+l][c];
    smp[1][2] += 30; smp[2][5] += 31;
    build_expect(3, 1'b0, 30);
    run_frame(3, 1'b0, 30);
    compare("R6 strict threshold");
    check(got_n == 1, "R6", "single hit at thr+1", got_n, 1);
  endtask

  task automatic t_saturate();
    write_ped(LANES + 2, 4, 0);
    for (int c = 0; c < NCOL; c++)
      for (int l = 0; l < LANES; l++) smp[l][c] = ped_m[LANES+l][c] - 20;
    smp[2][4] = 255;
    smp[0][8] = ped_m[LANES][8] + 90;
    build_expect(1, 1'b0, 100);
    run_frame(1, 1'b0, 100);
    compare("R5 saturation");
    check(got_n > 0 && got_w[0][7:0] == 8'd255, "R5", "saturated value",
          got_w[0][7:0], 255);
  endtask

  task automatic t_backpressure();
    for (int c = 0; c < NCOL; c++)
      for (int l = 0; l < LANES; l++)
        smp[l][c] = ped_m[2*LANES+l][c] + 4 + ((c * 5 + l) % 9 == 0 ? 70 : 0);
    bp_en = 1'b1;
    build_expect(2, 1'b0, 15);
    run_frame(2, 1'b0, 15);
    compare("R9 back-pressure");
    check(stall_err == 0, "R9", "stalled word changed", stall_err, 0);
    for (int c = 0; c < NCOL; c++)
      for (int l = 0; l < LANES; l++) smp[l][c] = (c * 13 + l * 29) % 256;
    build_expect(0, 1'b1, 0);
    run_frame(0, 1'b1, 0);
    compare("R9 raw under back-pressure");
    check(stall_err == 0, "R9", "stalled raw word changed", stall_err, 0);
    bp_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    load_ped_table();
    t_raw();
    t_common_pos();
    t_common_neg();
    t_all_hits();
    t_boundary();
    t_saturate();
    t_backpressure();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule